// File: doc/BRIEF.md
# Dual-Converter Sample Phase Scheduler

This block produces the sample-start strobes for two converter channels that share one sample clock. Each channel runs a short sequence of sampling steps. The length of each step's sampling period comes from a per-step hold-time code. Within every period, the channel strobes once. The strobe falls at a programmable lag of 0 to 15 clocks behind the start of the period. With a lag of 0 on one channel and 8 on the other, and the shortest hold code everywhere, the two channels strobe alternately every 8 clocks. This doubles the effective sample rate of one input.

A channel starts on its own trigger or on a trigger shared by both channels. A channel can also be told to wait for a global sync: its trigger then only arms it, and a later sync pulse starts every armed channel in the same cycle. A started channel captures its lag and its hold codes, so a later change to them only applies to the next sequence. The block exposes a window-active flag per channel that is high while the channel's sequence runs.

Top module: `dual_phase_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every strobe and every window flag is low.
- R2: A channel that is enabled, not waiting for sync, and idle starts when its selected trigger is high at a clock edge. `trig_sel` bit 0 selects the channel's own trigger and bit 1 selects the shared trigger. Its window flag is high from the cycle after that edge. The trigger that is not selected has no effect.
- R3: With a lag of 0, the strobe is high in the first cycle of each sampling period, starting with the first cycle of the window.
- R4: With lag p, the strobe is a single-cycle pulse in cycle p of every sampling period, counted from 0, and in no other cycle.
- R5: Step s of a sequence lasts 16 shifted left by its 2-bit hold code: code 0 gives 16 clocks, code 1 gives 32, code 2 gives 64 and code 3 gives 128. After the last of the 4 steps, the window flag falls and the channel goes idle.
- R6: A channel with sync-wait set is only armed by its trigger, with no window and no strobe. A sync pulse starts all armed channels in the same cycle. A sync pulse reaching a channel that is not armed is ignored.
- R7: The lag and hold codes are captured when a sequence starts. Changing them while the sequence runs does not move its strobes. The new values apply from the next start.
- R8: Clearing a channel's enable ends its window and strobes from the next cycle. A fresh start after re-enabling gives strobes aligned to that new start.
- R9: When both channels start on one sync with lags 0 and 8 and all hold codes 0, their strobes alternate every 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_en | input | NCH | Per-channel sequence enable |
| trig_own | input | NCH | Per-channel private trigger |
| trig_shared | input | 1 | Trigger common to all channels |
| trig_sel | input | NCH | 1 selects the shared trigger for that channel |
| sync_wait | input | NCH | 1 makes the trigger only arm the channel |
| gsync | input | 1 | Global sync pulse that starts armed channels |
| phase_i | input | NCH*PH_W | Per-channel lag, channel c at bits c*PH_W |
| hold_i | input | NCH*NSTEP*HC_W | Hold codes, channel c step s at (c*NSTEP+s)*HC_W |
| strobe_o | output | NCH | Single-cycle sample-start strobe |
| window_o | output | NCH | High while the channel's sequence runs |

## Verification
A start is registered at the edge that samples the trigger or the sync pulse, so the window is due in the very next cycle. The strobe of step s is due in the cycle that comes (the summed periods of earlier steps + lag) later. The window falls one full sequence length after it rose, and a disable shows one cycle after it is driven. The bench counts cycles with its own counter, changes inputs on the falling edge, and computes each strobe's due cycle from its own copy of the lag and hold codes at the moment it starts a channel. A monitor then compares the actual strobes, on falling edges, against those queued cycle numbers, which catches early, late, missing and extra pulses.

// File: rtl/phase_sched_pkg.sv
// Package: shared types for the dual-converter sample phase scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package phase_sched_pkg;

    // Per-channel sequencer state.
    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_ARMED = 2'd1,
        CS_RUN   = 2'd2
    } chan_state_t;

endpackage

// File: rtl/trig_route.sv
// Module: trig_route
// Selects, per channel, either that channel's private trigger or the
// shared trigger. Assumes triggers are already synchronous to clk.
module trig_route #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] trig_own,
    input  logic           trig_shared,
    input  logic [NCH-1:0] trig_sel,
    output logic [NCH-1:0] trig_eff
);

    for (genvar c = 0; c < NCH; c++) begin : g_route
        // Per-channel trigger source mux.
        always_comb trig_eff[c] = trig_sel[c] ? trig_shared : trig_own[c];
    end

endmodule

// File: rtl/chan_seq.sv
// Module: chan_seq
// One channel's sequencer. It runs NSTEP sampling periods and strobes once
// per period, at the captured lag. It captures the lag and hold codes at
// the start. Assumes MIN_PER > 2**PH_W - 1, so every lag fits in a period.
module chan_seq
    import phase_sched_pkg::*;
#(
    parameter int PH_W    = 4,
    parameter int HC_W    = 2,
    parameter int NSTEP   = 4,
    parameter int MIN_PER = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  trig,
    input  logic                  sync_wait,
    input  logic                  gsync,
    input  logic [PH_W-1:0]       phase,
    input  logic [NSTEP*HC_W-1:0] hold,
    output logic                  strobe,
    output logic                  window
);

    localparam int MAX_PER = MIN_PER << ((1 << HC_W) - 1);
    localparam int CNT_W   = $clog2(MAX_PER);
    localparam int STEP_W  = (NSTEP > 1) ? $clog2(NSTEP) : 1;

    chan_state_t           state_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [STEP_W-1:0]     step_q;
    logic [PH_W-1:0]       ph_q;
    logic [NSTEP*HC_W-1:0] hold_q;

    logic [HC_W-1:0]       cur_code;
    logic [CNT_W-1:0]      last_cnt;
    logic                  start_now;
    logic                  arm_now;
    logic                  period_end;
    logic                  last_step;

    // Pick the captured hold code of the current step.
    always_comb begin
        cur_code = '0;
        for (int s = 0; s < NSTEP; s++) begin
            if (step_q == STEP_W'(s)) cur_code = hold_q[s*HC_W +: HC_W];
        end
    end

    // Last count value of the current sampling period.
    always_comb last_cnt = CNT_W'((MIN_PER << cur_code) - 1);

    // Start and arm conditions.
    always_comb begin
        start_now = en && (((state_q == CS_IDLE) && trig && !sync_wait) ||
                           ((state_q == CS_ARMED) && gsync));
        arm_now   = en && (state_q == CS_IDLE) && trig && sync_wait;
    end

    // Period and sequence boundaries.
    always_comb begin
        period_end = (state_q == CS_RUN) && (cnt_q == last_cnt);
        last_step  = (step_q == STEP_W'(NSTEP - 1));
    end

    // Sequencer state, period counter and step index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            cnt_q   <= '0;
            step_q  <= '0;
        end else if (!en) begin
            state_q <= CS_IDLE;
            cnt_q   <= '0;
            step_q  <= '0;
        end else if (start_now) begin
            state_q <= CS_RUN;
            cnt_q   <= '0;
            step_q  <= '0;
        end else if (arm_now) begin
            state_q <= CS_ARMED;
        end else if (period_end) begin
            cnt_q <= '0;
            if (last_step) begin
                state_q <= CS_IDLE;
                step_q  <= '0;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end else if (state_q == CS_RUN) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Capture lag and hold codes at the sequence start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            hold_q <= '0;
        end else if (start_now) begin
            ph_q   <= phase;
            hold_q <= hold;
        end
    end

    // Outputs decoded from registered state.
    always_comb begin
        window = (state_q == CS_RUN);
        strobe = (state_q == CS_RUN) && (cnt_q == CNT_W'(ph_q));
    end

endmodule

// File: rtl/dual_phase_sched.sv
// Module: dual_phase_sched (top)
// Routes triggers and instantiates one sequencer per channel. All channels
// share the global sync pulse. Assumes every input is synchronous to clk.
module dual_phase_sched #(
    parameter int NCH     = 2,
    parameter int PH_W    = 4,
    parameter int HC_W    = 2,
    parameter int NSTEP   = 4,
    parameter int MIN_PER = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            seq_en,
    input  logic [NCH-1:0]            trig_own,
    input  logic                      trig_shared,
    input  logic [NCH-1:0]            trig_sel,
    input  logic [NCH-1:0]            sync_wait,
    input  logic                      gsync,
    input  logic [NCH*PH_W-1:0]       phase_i,
    input  logic [NCH*NSTEP*HC_W-1:0] hold_i,
    output logic [NCH-1:0]            strobe_o,
    output logic [NCH-1:0]            window_o
);

    localparam int HOLD_PER_CH = NSTEP * HC_W;

    logic [NCH-1:0] trig_eff;

    trig_route #(.NCH(NCH)) u_route (
        .trig_own    (trig_own),
        .trig_shared (trig_shared),
        .trig_sel    (trig_sel),
        .trig_eff    (trig_eff)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_seq #(
            .PH_W    (PH_W),
            .HC_W    (HC_W),
            .NSTEP   (NSTEP),
            .MIN_PER (MIN_PER)
        ) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (seq_en[c]),
            .trig      (trig_eff[c]),
            .sync_wait (sync_wait[c]),
            .gsync     (gsync),
            .phase     (phase_i[c*PH_W +: PH_W]),
            .hold      (hold_i[c*HOLD_PER_CH +: HOLD_PER_CH]),
            .strobe    (strobe_o[c]),
            .window    (window_o[c])
        );
    end

endmodule

// File: rtl/dual_phase_sched_chk.sv
// Module: dual_phase_sched_chk
// Port-level checker for dual_phase_sched, bound onto the top module.
module dual_phase_sched_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] seq_en,
    input logic [NCH-1:0] trig_own,
    input logic           trig_shared,
    input logic           gsync,
    input logic [NCH-1:0] strobe_o,
    input logic [NCH-1:0] window_o
);

    // R1: outputs are quiet in the cycle after a reset edge.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (strobe_o == '0) && (window_o == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R4: a strobe only occurs inside a running window.
        a_r4_strobe_in_window: assert property (@(posedge clk) disable iff (!rst_n)
            strobe_o[c] |-> window_o[c]);

        // R4: each strobe lasts exactly one cycle.
        a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            strobe_o[c] |=> !strobe_o[c]);

        // R8: disabling a channel ends its window at the next cycle.
        a_r8_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
            !seq_en[c] |=> !window_o[c]);

        // R2 and R6: a window only opens after a trigger or a sync pulse.
        a_r2_start_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
            (!window_o[c] && !trig_own[c] && !trig_shared && !gsync) |=> !window_o[c]);
    end

endmodule

bind dual_phase_sched dual_phase_sched_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_en      (seq_en),
    .trig_own    (trig_own),
    .trig_shared (trig_shared),
    .gsync       (gsync),
    .strobe_o    (strobe_o),
    .window_o    (window_o)
);

// File: tb/tb_dual_phase_sched.sv
module tb_dual_phase_sched;
    localparam int NCH = 2, PH_W = 4, HC_W = 2, NSTEP = 4, MIN_PER = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] seq_en = '0, trig_own = '0, trig_sel = '0, sync_wait = '0;
    logic trig_shared = 1'b0, gsync = 1'b0;
    logic [NCH*PH_W-1:0] phase_i;
    logic [NCH*NSTEP*HC_W-1:0] hold_i;
    logic [NCH-1:0] strobe_o, window_o;

    logic [PH_W-1:0] ph_tb [NCH];
    logic [HC_W-1:0] hold_tb [NCH][NSTEP];

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R1";
    int exp_q0[$];
    int exp_q1[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Pack the bench's lag and hold settings onto the ports.
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            phase_i[c*PH_W +: PH_W] = ph_tb[c];
            for (int s = 0; s < NSTEP; s++)
                hold_i[(c*NSTEP+s)*HC_W +: HC_W] = hold_tb[c][s];
        end
    end

    dual_phase_sched dut (
        .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .trig_own(trig_own),
        .trig_shared(trig_shared), .trig_sel(trig_sel), .sync_wait(sync_wait),
        .gsync(gsync), .phase_i(phase_i), .hold_i(hold_i),
        .strobe_o(strobe_o), .window_o(window_o)
    );

    function automatic int qsize(int c);
        return (c == 0) ? exp_q0.size() : exp_q1.size();
    endfunction
    function automatic int qfront(int c);
        return (c == 0) ? exp_q0[0] : exp_q1[0];
    endfunction
    task automatic qpop(int c);
        if (c == 0) void'(exp_q0.pop_front()); else void'(exp_q1.pop_front());
    endtask
    task automatic qpush(int c, int v);
        if (c == 0) exp_q0.push_back(v); else exp_q1.push_back(v);
    endtask
    task automatic qclear(int c);
        if (c == 0) exp_q0.delete(); else exp_q1.delete();
    endtask

    function automatic int seq_len(int c);
        int t = 0;
        for (int s = 0; s < NSTEP; s++) t += MIN_PER << hold_tb[c][s];
        return t;
    endfunction

    // Driver side: queue the due cycle of each strobe of a run starting at cycle n.
    task automatic expect_run(int c, int n);
        int off = 0;
        for (int s = 0; s < NSTEP; s++) begin
            qpush(c, n + off + int'(ph_tb[c]));
            off += MIN_PER << hold_tb[c][s];
        end
    endtask

    task automatic chk(int act, int exp, string msg);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, msg, act, exp);
        end
    endtask

    // Monitor: compare strobes with the queued due cycles.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < NCH; c++) begin
                while (qsize(c) > 0 && qfront(c) < cyc) begin
                    total++; bad++;
                    $display("FAIL %s ch%0d missed strobe actual=none expected=%0d", tag, c, qfront(c));
                    qpop(c);
                end
                if (strobe_o[c]) begin
                    total++;
                    if (qsize(c) > 0 && qfront(c) == cyc) qpop(c);
                    else begin
                        bad++;
                        $display("FAIL %s ch%0d unexpected strobe actual=%0d expected=%0d",
                                 tag, c, cyc, (qsize(c) > 0) ? qfront(c) : -1);
                    end
                end
            end
        end
    end

    // Wait out a run of length len started at the current cycle, checking the window.
    task automatic wait_run(int c, int len);
        chk(int'(window_o[c]), 1, $sformatf("ch%0d window at start", c));
        repeat (len - 1) @(negedge clk);
        chk(int'(window_o[c]), 1, $sformatf("ch%0d window last cycle", c));
        @(negedge clk);
        chk(int'(window_o[c]), 0, $sformatf("ch%0d window after run", c));
        chk(qsize(c), 0, $sformatf("ch%0d strobes left", c));
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            ph_tb[c] = '0;
            for (int s = 0; s < NSTEP; s++) hold_tb[c][s] = '0;
        end
        repeat (3) @(negedge clk);
        tag = "R1";
        chk(int'(window_o), 0, "window in reset");
        chk(int'(strobe_o), 0, "strobe in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(window_o), 0, "window after reset");
        seq_en = 2'b11;

        // R3, R5: own trigger, lag 0, shortest period.
        tag = "R3";
        trig_own[0] = 1'b1; expect_run(0, cyc + 1);
        @(negedge clk); trig_own[0] = 1'b0;
        wait_run(0, seq_len(0));

        // R4, R5: lag 5 with mixed hold codes 0,1,0,2.
        tag = "R4";
        ph_tb[1] = 4'd5;
        hold_tb[1][0] = 2'd0; hold_tb[1][1] = 2'd1; hold_tb[1][2] = 2'd0; hold_tb[1][3] = 2'd2;
        chk(seq_len(1), 128, "R5 period sum");
        trig_own[1] = 1'b1; expect_run(1, cyc + 1);
        @(negedge clk); trig_own[1] = 1'b0;
        wait_run(1, seq_len(1));

        // R2: shared trigger selected; own trigger then has no effect.
        tag = "R2";
        trig_sel = 2'b11; ph_tb[1] = 4'd3;
        trig_own[1] = 1'b1;
        @(negedge clk); trig_own[1] = 1'b0;
        chk(int'(window_o[1]), 0, "ch1 own trigger ignored");
        trig_shared = 1'b1; expect_run(0, cyc + 1); expect_run(1, cyc + 1);
        @(negedge clk); trig_shared = 1'b0;
        chk(int'(window_o[0]), 1, "ch0 shared start");
        wait_run(1, seq_len(1));
        trig_sel = 2'b00;

        // R6, R9: sync-wait arming and joint start, 180-degree interleave.
        tag = "R6";
        sync_wait = 2'b11;
        for (int s = 0; s < NSTEP; s++) hold_tb[1][s] = '0;
        ph_tb[0] = 4'd0; ph_tb[1] = 4'd8;
        gsync = 1'b1;
        @(negedge clk); gsync = 1'b0;
        chk(int'(window_o), 0, "sync ignored when not armed");
        trig_own = 2'b11;
        @(negedge clk); trig_own = 2'b00;
        chk(int'(window_o), 0, "armed channels wait");
        repeat (3) @(negedge clk);
        chk(int'(window_o), 0, "still waiting");
        tag = "R9";
        gsync = 1'b1; expect_run(0, cyc + 1); expect_run(1, cyc + 1);
        @(negedge clk); gsync = 1'b0;
        chk(int'(window_o), 3, "R6 joint start");
        wait_run(1, seq_len(1));
        chk(int'(window_o[0]), 0, "ch0 done with ch1");
        sync_wait = 2'b00;

        // R7: lag change mid-sequence does not move strobes.
        tag = "R7";
        ph_tb[0] = 4'd2;
        trig_own[0] = 1'b1; expect_run(0, cyc + 1);
        @(negedge clk); trig_own[0] = 1'b0;
        repeat (5) @(negedge clk);
        ph_tb[0] = 4'd9; hold_tb[0][1] = 2'd3;
        repeat (seq_len(0) - 64) @(negedge clk);
        @(negedge clk);
        chk(int'(window_o[0]), 0, "old run ended with old holds");
        chk(qsize(0), 0, "old lag kept");
        trig_own[0] = 1'b1; expect_run(0, cyc + 1);
        @(negedge clk); trig_own[0] = 1'b0;
        wait_run(0, seq_len(0));

        // R8: disable mid-run, then restart aligned.
        tag = "R8";
        ph_tb[0] = 4'd0; hold_tb[0][1] = 2'd0;
        trig_own[0] = 1'b1; expect_run(0, cyc + 1);
        @(negedge clk); trig_own[0] = 1'b0;
        repeat (20) @(negedge clk);
        seq_en[0] = 1'b0;
        @(negedge clk);
        chk(int'(window_o[0]), 0, "window off after disable");
        qclear(0);
        repeat (4) @(negedge clk);
        chk(int'(strobe_o[0]), 0, "no strobe while disabled");
        seq_en[0] = 1'b1;
        ph_tb[0] = 4'd7;
        trig_own[0] = 1'b1; expect_run(0, cyc + 1);
        @(negedge clk); trig_own[0] = 1'b0;
        wait_run(0, seq_len(0));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule